// File: doc/BRIEF.md
# Overload and Thermal Protection Sequencer

This block is the digital controller that decides whether the regulated output stage of a supply may drive its load. It watches a synchronized overload-detect signal from the analog current clamp, a pair of hysteretic temperature comparators (a trip input and a cool-down release input), the global enable and an undervoltage lockout. It produces the enable for the power stage, the control of the loop-through bypass switch, and two status flags: an overload flag and an over-temperature flag.

Two overload policies are selected by a mode input. In dynamic mode an overload starts a hiccup cycle. The output is cut for an off window, then re-enabled for an on window one tenth as long. The cycle repeats until an on window passes with no overload. In static mode the output stays on and the overload flag only mirrors the clamp. A one-cycle tick, typically one per millisecond, paces both windows. Thermal shutdown overrides everything else except disable and lockout.

Top module: `prot_seq`

## Requirements
- R1: In dynamic mode (pcl_i = 0), with the block active, no thermal event and the sequencer idle, an overload on ovl_i drops out_en_o and sets olf_o at the next clock edge.
- R2: The off window lasts T_OFF_TICKS ticks. The output is then re-enabled for an on window of T_OFF_TICKS/10 ticks, and olf_o stays high through both windows.
- R3: An overload seen at any point during the on window, including its last cycle, starts a fresh off window at the end of that window.
- R4: An on window that ends with no overload seen returns the sequencer to normal: out_en_o stays high and olf_o clears at the edge that closes the window.
- R5: In static mode (pcl_i = 1) out_en_o stays high whatever ovl_i does. olf_o equals ovl_i delayed by one clock, and setting pcl_i abandons any hiccup cycle in progress.
- R6: hot_i sets otf_o and drops out_en_o at the next edge. otf_o then stays set until cool_i is seen with hot_i low; if both are high, hot_i wins.
- R7: lt_close_o is high exactly when en_i = 1'b0 and uvlo_i = 1'b0. out_en_o is low whenever en_i is low.
- R8: Clearing pcl_i while ovl_i is high starts an off window at the next edge.
- R9: en_i = 0 or uvlo_i = 1 clears olf_o, otf_o and the window timer at the next edge, and the sequencer restarts idle. uvlo_i = 1 also keeps lt_close_o low.
- R10: While otf_o is set, or hot_i is high, the overload timer and olf_o are frozen. On release the off window resumes from the count it had reached.
- R11: The window timer advances only on cycles where tick_i is high.
- R12: The asynchronous reset rst_ni clears olf_o and otf_o at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle timer tick (nominally 1 ms) |
| en_i | input | 1 | Power enable; low closes the bypass switch |
| uvlo_i | input | 1 | Undervoltage lockout, high = supply too low |
| pcl_i | input | 1 | Overload policy: 0 dynamic hiccup, 1 static report |
| ovl_i | input | 1 | Synchronized overload-detect from the clamp |
| hot_i | input | 1 | Over-temperature trip comparator |
| cool_i | input | 1 | Cool-down release comparator |
| out_en_o | output | 1 | Power stage enable |
| lt_close_o | output | 1 | Loop-through switch close |
| olf_o | output | 1 | Overload flag |
| otf_o | output | 1 | Over-temperature flag |

## Verification
The bench measures the off and on windows to the exact edge. A timer that is off by one leaves the output on or off one cycle too long. It places an overload in the middle of an on window and then clears it before the window's last cycle; a design that only samples at the window's end would wrongly resume. It trips the thermal input in the middle of an off window and holds it for many cycles. A design that kept counting would re-enable too early once the part cooled. It also checks that the trip input wins over a simultaneous release and that a dropped enable or a lockout clears a pending hiccup, so that the output comes back at once instead of finishing the cycle. Further cases cover a policy change from static to dynamic while the overload is held, and idle cycles with the tick held low.

// File: rtl/prot_seq_pkg.sv
package prot_seq_pkg;
  typedef enum logic [1:0] {
    HC_IDLE = 2'd0,
    HC_OFF  = 2'd1,
    HC_ON   = 2'd2
  } hc_state_e;
endpackage

// File: rtl/prot_thermal.sv
module prot_thermal (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic hot_i,
  input  logic cool_i,
  output logic otf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        otf_o <= 1'b0;
    else if (!active_i) otf_o <= 1'b0;
    else if (hot_i)     otf_o <= 1'b1;
    else if (cool_i)    otf_o <= 1'b0;
  end

  // R6
  hyst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && otf_o && !cool_i) |=> otf_o);
endmodule

// File: rtl/prot_hiccup.sv
module prot_hiccup
  import prot_seq_pkg::*;
#(
  parameter int T_OFF_TICKS = 900
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic hold_i,
  input  logic tick_i,
  input  logic pcl_i,
  input  logic ovl_i,
  output logic cut_o,
  output logic olf_o
);
  localparam int T_ON_TICKS = (T_OFF_TICKS / 10 > 0) ? T_OFF_TICKS / 10 : 1;
  localparam int CW = $clog2(T_OFF_TICKS + 1);
  localparam logic [CW-1:0] OFF_LAST = CW'(T_OFF_TICKS - 1);
  localparam logic [CW-1:0] ON_LAST  = CW'(T_ON_TICKS - 1);

  hc_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HC_IDLE;
      cnt_q   <= '0;
      seen_q  <= 1'b0;
      olf_o   <= 1'b0;
    end else if (!active_i) begin
      state_q <= HC_IDLE;
      cnt_q   <= '0;
      seen_q  <= 1'b0;
      olf_o   <= 1'b0;
    end else if (hold_i) begin
      // frozen during thermal shutdown
    end else if (pcl_i) begin
      state_q <= HC_IDLE;
      cnt_q   <= '0;
      seen_q  <= 1'b0;
      olf_o   <= ovl_i;
    end else begin
      unique case (state_q)
        HC_IDLE: begin
          if (ovl_i) begin
            state_q <= HC_OFF;
            cnt_q   <= '0;
            olf_o   <= 1'b1;
          end else begin
            olf_o   <= 1'b0;
          end
        end
        HC_OFF: begin
          if (tick_i) begin
            if (cnt_q == OFF_LAST) begin
              state_q <= HC_ON;
              cnt_q   <= '0;
              seen_q  <= 1'b0;
            end else begin
              cnt_q   <= cnt_q + 1'b1;
            end
          end
        end
        HC_ON: begin
          if (ovl_i) seen_q <= 1'b1;
          if (tick_i) begin
            if (cnt_q == ON_LAST) begin
              cnt_q <= '0;
              if (seen_q || ovl_i) begin
                state_q <= HC_OFF;
              end else begin
                state_q <= HC_IDLE;
                olf_o   <= 1'b0;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= HC_IDLE;
      endcase
    end
  end

  assign cut_o = (state_q == HC_OFF);

  // R1
  trip_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !hold_i && !pcl_i && ovl_i && state_q == HC_IDLE) |=> (cut_o && olf_o));

  // R10
  hold_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && hold_i) |=> ($stable(cnt_q) && $stable(olf_o)));

  // R11
  tick_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !hold_i && !pcl_i && !tick_i && state_q == HC_OFF) |=> (cut_o && $stable(cnt_q)));
endmodule

// File: rtl/prot_seq.sv
module prot_seq #(
  parameter int T_OFF_TICKS = 900
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  input  logic uvlo_i,
  input  logic pcl_i,
  input  logic ovl_i,
  input  logic hot_i,
  input  logic cool_i,
  output logic out_en_o,
  output logic lt_close_o,
  output logic olf_o,
  output logic otf_o
);
  logic active, cut, hold;

  assign active = en_i & ~uvlo_i;
  assign hold   = otf_o | hot_i;

  prot_thermal u_thermal (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .hot_i    (hot_i),
    .cool_i   (cool_i),
    .otf_o    (otf_o)
  );

  prot_hiccup #(.T_OFF_TICKS(T_OFF_TICKS)) u_hiccup (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .hold_i   (hold),
    .tick_i   (tick_i),
    .pcl_i    (pcl_i),
    .ovl_i    (ovl_i),
    .cut_o    (cut),
    .olf_o    (olf_o)
  );

  assign out_en_o   = active & ~otf_o & ~cut;
  assign lt_close_o = ~en_i & ~uvlo_i;

  // R6
  therm_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !uvlo_i && hot_i) |=> (otf_o && !out_en_o));

  // R9
  inactive_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || uvlo_i) |=> (!olf_o && !otf_o));
endmodule

// File: tb/tb_prot_seq.sv
module tb_prot_seq;
  localparam int T_OFF = 20;
  localparam int NV = 42;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0, en_i = 1'b0, uvlo_i = 1'b0, pcl_i = 1'b0;
  logic ovl_i = 1'b0, hot_i = 1'b0, cool_i = 1'b0;
  logic out_en_o, lt_close_o, olf_o, otf_o;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prot_seq #(.T_OFF_TICKS(T_OFF)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .en_i(en_i), .uvlo_i(uvlo_i),
    .pcl_i(pcl_i), .ovl_i(ovl_i), .hot_i(hot_i), .cool_i(cool_i),
    .out_en_o(out_en_o), .lt_close_o(lt_close_o), .olf_o(olf_o), .otf_o(otf_o)
  );

  // {req, en uv pcl ovl hot cool tick, cycles, exp out_en lt olf otf}
  localparam logic [22:0] VEC [NV] = '{
    {4'd7,  7'b1000001, 8'd2,  4'b1000}, // R7 enabled, normal
    {4'd1,  7'b1001001, 8'd1,  4'b0010}, // R1 trip
    {4'd2,  7'b1000001, 8'd18, 4'b0010}, // R2 still off
    {4'd2,  7'b1000001, 8'd2,  4'b1010}, // R2 on window
    {4'd4,  7'b1000001, 8'd2,  4'b1000}, // R4 clean recovery
    {4'd1,  7'b1001001, 8'd1,  4'b0010}, // R1
    {4'd2,  7'b1000001, 8'd20, 4'b1010}, // R2
    {4'd3,  7'b1001001, 8'd1,  4'b1010}, // R3 overload mid window
    {4'd3,  7'b1000001, 8'd1,  4'b0010}, // R3 new off window
    {4'd2,  7'b1000001, 8'd20, 4'b1010}, // R2
    {4'd4,  7'b1000001, 8'd2,  4'b1000}, // R4
    {4'd5,  7'b1011001, 8'd1,  4'b1010}, // R5 static follows
    {4'd5,  7'b1010001, 8'd1,  4'b1000}, // R5
    {4'd5,  7'b1011001, 8'd3,  4'b1010}, // R5
    {4'd8,  7'b1001001, 8'd1,  4'b0010}, // R8 static to dynamic
    {4'd6,  7'b1000101, 8'd1,  4'b0011}, // R6 trip in off window
    {4'd10, 7'b1000001, 8'd30, 4'b0011}, // R10 frozen
    {4'd6,  7'b1000011, 8'd1,  4'b0010}, // R6 release
    {4'd10, 7'b1000001, 8'd19, 4'b0010}, // R10 resumes from held count
    {4'd10, 7'b1000001, 8'd1,  4'b1010}, // R10
    {4'd4,  7'b1000001, 8'd2,  4'b1000}, // R4
    {4'd6,  7'b1000101, 8'd1,  4'b0001}, // R6
    {4'd6,  7'b1000001, 8'd3,  4'b0001}, // R6 hysteresis
    {4'd6,  7'b1000011, 8'd1,  4'b1000}, // R6
    {4'd10, 7'b1001101, 8'd2,  4'b0001}, // R10 thermal wins over overload
    {4'd10, 7'b1000011, 8'd1,  4'b1000}, // R10
    {4'd1,  7'b1001001, 8'd1,  4'b0010}, // R1
    {4'd9,  7'b0000001, 8'd1,  4'b0100}, // R9 disable clears
    {4'd9,  7'b1000001, 8'd1,  4'b1000}, // R9 restarts idle
    {4'd1,  7'b1001001, 8'd1,  4'b0010}, // R1
    {4'd6,  7'b1000101, 8'd1,  4'b0011}, // R6
    {4'd9,  7'b1100001, 8'd1,  4'b0000}, // R9 lockout
    {4'd9,  7'b1000001, 8'd1,  4'b1000}, // R9
    {4'd7,  7'b0000101, 8'd2,  4'b0100}, // R7 disabled, hot ignored
    {4'd7,  7'b1000001, 8'd1,  4'b1000}, // R7
    {4'd1,  7'b1001001, 8'd1,  4'b0010}, // R1
    {4'd11, 7'b1000000, 8'd40, 4'b0010}, // R11 no ticks
    {4'd11, 7'b1000001, 8'd19, 4'b0010}, // R11
    {4'd11, 7'b1000001, 8'd1,  4'b1010}, // R11
    {4'd4,  7'b1000001, 8'd2,  4'b1000}, // R4
    {4'd6,  7'b1000111, 8'd1,  4'b0001}, // R6 trip beats release
    {4'd6,  7'b1000011, 8'd1,  4'b1000}  // R6
  };

  task automatic check(input int req, input logic [3:0] exp);
    logic [3:0] act;
    act = {out_en_o, lt_close_o, olf_o, otf_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: {out_en,lt,olf,otf} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(12, 4'b0100); // R12 reset state
    rst_ni = 1'b1;
    @(negedge clk);
    check(12, 4'b0100); // R12

    for (int i = 0; i < NV; i++) begin
      {en_i, uvlo_i, pcl_i, ovl_i, hot_i, cool_i, tick_i} = VEC[i][18:12];
      repeat (int'(VEC[i][11:4])) @(negedge clk);
      check(int'(VEC[i][22:19]), VEC[i][3:0]);
    end

    // R12 asynchronous reset in the middle of an off window
    {en_i, uvlo_i, pcl_i, ovl_i, hot_i, cool_i, tick_i} = 7'b1001001;
    @(negedge clk);
    check(1, 4'b0010);
    hot_i = 1'b1;
    @(negedge clk);
    check(6, 4'b0011);
    #1 rst_ni = 1'b0;
    #1 check(12, 4'b1000);
    @(negedge clk);
    rst_ni = 1'b1;
    {ovl_i, hot_i} = 2'b00;
    @(negedge clk);
    check(12, 4'b1000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule